// File: doc/BRIEF.md
# Instruction Cache Enable and Flash-Invalidate Control

This block is the control side of a small direct-mapped instruction cache. It holds a two-bit control register (an enable bit and a flash-invalidate bit), the valid bit and tag of every line, and the routing decision for each instruction fetch. A fetch either goes to the cache lookup, where it may hit, or it goes downstream. A downstream fetch is a full line fill when the cache is enabled and the fetch may be cached. Otherwise it is a single-beat transfer. Instruction data storage sits outside the block, and so does address translation. The enable bit does not touch translation.

Two reset inputs are separate. The hard reset (`rst`) stands for power-up and hard reset. It clears the register and every valid bit. The soft reset (`soft_rst`) clears only the register, so the cache contents survive. Software that wants a clean cache after a soft reset writes the flash-invalidate bit. Hardware clears that bit one clock after it is seen with the enable bit set. Software that clears the bit itself with a second write also works.

Top module: `icc_top`

## Requirements
- R1: After hard reset the register reads 0 and every line is invalid, so a later enabled fetch to a line filled before the reset misses.
- R2: The enable bit is register bit 0 and resets to 0. While it reads 0, every fetch gives down_req=1, down_burst=0, hit=0 and lookup_req=0, even for an address whose line is valid.
- R3: down_inhibit equals fetch_inhibit in every cycle, whether the cache is enabled or not.
- R4: When cfg_we=1 at a clock edge, cfg_wdata bit 0 (enable) and bit 1 (flash-invalidate) are loaded, and cfg_rdata shows them from the next cycle.
- R5: A flash-invalidate bit written as 1 together with enable=1 reads 1 for exactly one cycle and then reads 0 with no further write.
- R6: The edge that ends a cycle in which both bits read 1 clears every valid bit at once.
- R7: A fetch in a cycle where both bits read 1 is a miss, even when its line was valid.
- R8: A flash-invalidate bit that is set while enable is 0 stays set. Once enable is set, it reads 1 for one more cycle, then 0, and the invalidation takes place.
- R9: Soft reset clears both register bits but keeps every valid bit and tag. After re-enabling, a line filled before the soft reset hits.
- R10: A flash-invalidate write followed on the next cycle by a write that clears the bit still invalidates the cache.
- R11: A hit needs enable=1, a valid line, an equal tag and fetch_inhibit=0. An enabled, non-inhibited miss goes downstream with down_burst=1. An inhibited fetch goes downstream with down_burst=0.
- R12: A line fill request (fill_valid) is ignored while enable reads 0 and in a flash-invalidate cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous hard reset, active high (also power-up) |
| soft_rst | input | 1 | Synchronous soft reset, active high; clears the register only |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 2 | Write data: bit 0 enable, bit 1 flash-invalidate |
| cfg_rdata | output | 2 | Current register contents |
| fetch_valid | input | 1 | Fetch request present this cycle |
| fetch_addr | input | ADDR_W | Fetch address |
| fetch_inhibit | input | 1 | Caching-inhibited attribute of the fetch |
| fill_valid | input | 1 | A line fill completes this cycle |
| fill_addr | input | ADDR_W | Address of the completed fill |
| lookup_req | output | 1 | Fetch is presented to the cache lookup |
| hit | output | 1 | Fetch is served by the cache |
| down_req | output | 1 | Fetch goes downstream |
| down_burst | output | 1 | Downstream fetch is a line fill (0 = single beat) |
| down_inhibit | output | 1 | Caching-inhibited signal sent downstream |

## Verification
The bench focuses on when the flash-invalidate bit clears and what fetches see in that cycle. A design that clears the bit in the write edge itself, or one cycle too late, reads the wrong register value. A design that still hits during the flash cycle returns an instruction that should be gone. The bench sets the bit while the cache is disabled and checks that it survives until enable is set. It also runs the two-write clearing sequence, where a design that honours only the auto-clear path would miss the invalidation. Soft and hard reset are each followed by a fetch to a line filled earlier, which catches a design that mixes up the two. Disabled-mode fetches to valid lines catch a design that still consults the tags.

// File: rtl/icc_pkg.sv
package icc_pkg;

    localparam int CTL_W = 2;

    typedef struct packed {
        logic fi;   // bit 1: flash-invalidate request
        logic en;   // bit 0: cache enable
    } ctl_t;

    typedef enum logic [1:0] {
        RT_IDLE   = 2'd0,
        RT_HIT    = 2'd1,
        RT_LINE   = 2'd2,
        RT_SINGLE = 2'd3
    } route_e;

    function automatic route_e pick_route(
        input logic fv,
        input logic en,
        input logic inh,
        input logic flash,
        input logic match
    );
        route_e r;
        if (!fv)                  r = RT_IDLE;
        else if (!en || inh)      r = RT_SINGLE;
        else if (match && !flash) r = RT_HIT;
        else                      r = RT_LINE;
        return r;
    endfunction

endpackage

// File: rtl/icc_ctrl_reg.sv
module icc_ctrl_reg
    import icc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             soft_rst,
    input  logic             we,
    input  logic [CTL_W-1:0] wdata,
    output ctl_t             ctl,
    output logic             flash_now
);
    ctl_t ctl_q;

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            ctl_q <= '0;
        end else if (we) begin
            ctl_q <= ctl_t'(wdata);
        end else if (ctl_q.fi && ctl_q.en) begin
            ctl_q.fi <= 1'b0;
        end
    end

    assign ctl       = ctl_q;
    assign flash_now = ctl_q.fi & ctl_q.en;
endmodule

// File: rtl/icc_tag_store.sv
module icc_tag_store #(
    parameter int LINES = 16,
    parameter int TAG_W = 23,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flash,
    input  logic             fill_en,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [TAG_W-1:0] rd_tag,
    output logic             rd_match
);
    logic [LINES-1:0] line_vld;
    logic [TAG_W-1:0] line_tag [LINES];

    for (genvar i = 0; i < LINES; i++) begin : g_line
        logic             v_q;
        logic [TAG_W-1:0] t_q;
        logic             sel;

        assign sel = fill_en && (fill_idx == IDX_W'(i));

        always_ff @(posedge clk) begin
            if (rst || flash) begin
                v_q <= 1'b0;
            end else if (sel) begin
                v_q <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                t_q <= '0;
            end else if (sel && !flash) begin
                t_q <= fill_tag;
            end
        end

        assign line_vld[i] = v_q;
        assign line_tag[i] = t_q;
    end

    assign rd_match = line_vld[rd_idx] && (line_tag[rd_idx] == rd_tag);
endmodule

// File: rtl/icc_route.sv
module icc_route
    import icc_pkg::*;
(
    input  logic fetch_valid,
    input  logic fetch_inhibit,
    input  logic en,
    input  logic flash,
    input  logic match,
    output logic lookup_req,
    output logic hit,
    output logic down_req,
    output logic down_burst,
    output logic down_inhibit
);
    route_e rt;

    always_comb begin
        rt           = pick_route(fetch_valid, en, fetch_inhibit, flash, match);
        lookup_req   = fetch_valid && en && !fetch_inhibit;
        hit          = (rt == RT_HIT);
        down_req     = (rt == RT_LINE) || (rt == RT_SINGLE);
        down_burst   = (rt == RT_LINE);
        down_inhibit = fetch_inhibit;
    end
endmodule

// File: rtl/icc_top.sv
module icc_top
    import icc_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 32,
    parameter int LINES      = 16,
    localparam int OFF_W = $clog2(LINE_BYTES),
    localparam int IDX_W = $clog2(LINES),
    localparam int TAG_W = ADDR_W - OFF_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              soft_rst,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_wdata,
    output logic [1:0]        cfg_rdata,
    input  logic              fetch_valid,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              fetch_inhibit,
    input  logic              fill_valid,
    input  logic [ADDR_W-1:0] fill_addr,
    output logic              lookup_req,
    output logic              hit,
    output logic              down_req,
    output logic              down_burst,
    output logic              down_inhibit
);
    ctl_t ctl;
    logic flash_now;
    logic match;
    logic fill_en;

    icc_ctrl_reg u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .soft_rst  (soft_rst),
        .we        (cfg_we),
        .wdata     (cfg_wdata),
        .ctl       (ctl),
        .flash_now (flash_now)
    );

    assign fill_en = fill_valid && ctl.en && !flash_now;

    icc_tag_store #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
        .clk      (clk),
        .rst      (rst),
        .flash    (flash_now),
        .fill_en  (fill_en),
        .fill_idx (fill_addr[OFF_W +: IDX_W]),
        .fill_tag (fill_addr[ADDR_W-1 -: TAG_W]),
        .rd_idx   (fetch_addr[OFF_W +: IDX_W]),
        .rd_tag   (fetch_addr[ADDR_W-1 -: TAG_W]),
        .rd_match (match)
    );

    icc_route u_route (
        .fetch_valid   (fetch_valid),
        .fetch_inhibit (fetch_inhibit),
        .en            (ctl.en),
        .flash         (flash_now),
        .match         (match),
        .lookup_req    (lookup_req),
        .hit           (hit),
        .down_req      (down_req),
        .down_burst    (down_burst),
        .down_inhibit  (down_inhibit)
    );

    assign cfg_rdata = ctl;
endmodule

// File: rtl/icc_checker.sv
module icc_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              soft_rst,
    input logic              cfg_we,
    input logic [1:0]        cfg_wdata,
    input logic [1:0]        cfg_rdata,
    input logic              fetch_valid,
    input logic [ADDR_W-1:0] fetch_addr,
    input logic              fetch_inhibit,
    input logic              fill_valid,
    input logic [ADDR_W-1:0] fill_addr,
    input logic              lookup_req,
    input logic              hit,
    input logic              down_req,
    input logic              down_burst,
    input logic              down_inhibit
);
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> cfg_rdata == 2'b00);

    p_disabled_bypass_r2: assert property (@(posedge clk) disable iff (rst)
        (fetch_valid && !cfg_rdata[0]) |-> (down_req && !down_burst && !hit && !lookup_req));

    p_inhibit_follow_r3: assert property (@(posedge clk) disable iff (rst)
        down_inhibit == fetch_inhibit);

    p_write_load_r4: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && !soft_rst) |=> cfg_rdata == $past(cfg_wdata));

    p_auto_clear_r5: assert property (@(posedge clk) disable iff (rst)
        (cfg_rdata == 2'b11 && !cfg_we && !soft_rst) |=> !cfg_rdata[1]);

    p_flash_miss_r7: assert property (@(posedge clk) disable iff (rst)
        (cfg_rdata == 2'b11) |-> !hit);

    p_flash_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (cfg_rdata == 2'b10 && !cfg_we && !soft_rst) |=> cfg_rdata == 2'b10);

    p_hit_exclusive_r11: assert property (@(posedge clk) disable iff (rst)
        hit |-> (!down_req && !fetch_inhibit && fetch_valid));
endmodule

bind icc_top icc_checker #(.ADDR_W(ADDR_W)) i_chk (.*);

// File: tb/test_icc_top.sv
`timescale 1ns/1ps
module test_icc_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        soft_rst = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_wdata = '0;
    logic [1:0]  cfg_rdata;
    logic        fetch_valid = 1'b0;
    logic [31:0] fetch_addr = '0;
    logic        fetch_inhibit = 1'b0;
    logic        fill_valid = 1'b0;
    logic [31:0] fill_addr = '0;
    logic        lookup_req, hit, down_req, down_burst, down_inhibit;

    always #4 clk = ~clk;

    icc_top i_icc_top (.*);

    typedef struct {
        string      req;
        logic       e_hit;
        logic       e_dreq;
        logic       e_burst;
        logic       e_inh;
        logic [1:0] e_rd;
    } exp_t;

    exp_t q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;

    localparam logic [31:0] A  = 32'h0000_1020; // line 1
    localparam logic [31:0] B  = 32'h0000_3020; // line 1, other tag
    localparam logic [31:0] C  = 32'h0000_0040; // line 2

    task automatic cyc(input string r, input bit we, input logic [1:0] wd,
                       input bit fv, input logic [31:0] a, input bit inh,
                       input bit fl, input logic [31:0] fa, input bit sr,
                       input logic eh, input logic ed, input logic eb,
                       input logic [1:0] erd);
        exp_t e;
        cfg_we = we; cfg_wdata = wd;
        fetch_valid = fv; fetch_addr = a; fetch_inhibit = inh;
        fill_valid = fl; fill_addr = fa; soft_rst = sr;
        e.req = r; e.e_hit = eh; e.e_dreq = ed; e.e_burst = eb;
        e.e_inh = inh; e.e_rd = erd;
        q.push_back(e);
        @(negedge clk);
    endtask

    // monitor: compares outputs mid-cycle, away from the rising edge
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                n_cmp++;
                if (hit !== e.e_hit || down_req !== e.e_dreq || down_burst !== e.e_burst ||
                    down_inhibit !== e.e_inh || cfg_rdata !== e.e_rd) begin
                    n_bad++;
                    $display("FAIL %s: got hit=%b dreq=%b burst=%b inh=%b rd=%b exp hit=%b dreq=%b burst=%b inh=%b rd=%b",
                             e.req, hit, down_req, down_burst, down_inhibit, cfg_rdata,
                             e.e_hit, e.e_dreq, e.e_burst, e.e_inh, e.e_rd);
                end
            end
        end
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: got running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        //   req         we wd    fv a  inh fl fa sr  hit dreq burst rd
        cyc("R1/R2 rst", 0, 2'b00, 1, A, 0, 0, 0, 0,  0, 1, 0, 2'b00);
        cyc("R12 dis",   0, 2'b00, 0, 0, 0, 1, A, 0,  0, 0, 0, 2'b00);
        cyc("R4 wr",     1, 2'b01, 1, A, 0, 0, 0, 0,  0, 1, 0, 2'b00);
        cyc("R12 miss",  0, 2'b00, 1, A, 0, 0, 0, 0,  0, 1, 1, 2'b01);
        cyc("R4 fill",   0, 2'b00, 0, 0, 0, 1, A, 0,  0, 0, 0, 2'b01);
        cyc("R11 hit",   0, 2'b00, 1, A, 0, 0, 0, 0,  1, 0, 0, 2'b01);
        cyc("R11 tag",   0, 2'b00, 1, B, 0, 0, 0, 0,  0, 1, 1, 2'b01);
        cyc("R3 inh",    0, 2'b00, 1, A, 1, 0, 0, 0,  0, 1, 0, 2'b01);
        cyc("R11 fillC", 0, 2'b00, 0, 0, 0, 1, C, 0,  0, 0, 0, 2'b01);
        cyc("R5 wr",     1, 2'b11, 1, A, 0, 0, 0, 0,  1, 0, 0, 2'b01);
        cyc("R7 flash",  0, 2'b00, 1, A, 0, 0, 0, 0,  0, 1, 1, 2'b11);
        cyc("R6 C gone", 0, 2'b00, 1, C, 0, 0, 0, 0,  0, 1, 1, 2'b01);
        cyc("R5 clear",  0, 2'b00, 1, A, 0, 0, 0, 0,  0, 1, 1, 2'b01);
        // soft reset keeps contents
        cyc("R9 fill",   0, 2'b00, 0, 0, 0, 1, A, 0,  0, 0, 0, 2'b01);
        cyc("R9 hit",    0, 2'b00, 1, A, 0, 0, 0, 0,  1, 0, 0, 2'b01);
        cyc("R9 srst",   0, 2'b00, 1, A, 0, 0, 0, 1,  1, 0, 0, 2'b01);
        cyc("R9 dis",    0, 2'b00, 1, A, 0, 0, 0, 0,  0, 1, 0, 2'b00);
        cyc("R9 en",     1, 2'b01, 0, 0, 0, 0, 0, 0,  0, 0, 0, 2'b00);
        cyc("R9 kept",   0, 2'b00, 1, A, 0, 0, 0, 0,  1, 0, 0, 2'b01);
        // flash requested while disabled
        cyc("R8 off",    1, 2'b00, 1, A, 0, 0, 0, 0,  1, 0, 0, 2'b01);
        cyc("R8 set",    1, 2'b10, 0, 0, 0, 0, 0, 0,  0, 0, 0, 2'b00);
        cyc("R8 hold1",  0, 2'b00, 0, 0, 0, 0, 0, 0,  0, 0, 0, 2'b10);
        cyc("R8 hold2",  1, 2'b11, 1, A, 0, 0, 0, 0,  0, 1, 0, 2'b10);
        cyc("R8 flash",  0, 2'b00, 1, A, 0, 0, 0, 0,  0, 1, 1, 2'b11);
        cyc("R8 after",  0, 2'b00, 1, A, 0, 0, 0, 0,  0, 1, 1, 2'b01);
        // set-then-clear by two writes
        cyc("R10 fill",  0, 2'b00, 0, 0, 0, 1, A, 0,  0, 0, 0, 2'b01);
        cyc("R10 hit",   0, 2'b00, 1, A, 0, 0, 0, 0,  1, 0, 0, 2'b01);
        cyc("R10 set",   1, 2'b11, 0, 0, 0, 0, 0, 0,  0, 0, 0, 2'b01);
        cyc("R10 clr",   1, 2'b01, 1, A, 0, 0, 0, 0,  0, 1, 1, 2'b11);
        cyc("R10 gone",  0, 2'b00, 1, A, 0, 0, 0, 0,  0, 1, 1, 2'b01);
        // inhibit passthrough while disabled
        cyc("R3 off",    1, 2'b00, 0, 0, 0, 0, 0, 0,  0, 0, 0, 2'b01);
        cyc("R3 dis",    0, 2'b00, 1, C, 1, 0, 0, 0,  0, 1, 0, 2'b00);
        // hard reset clears lines
        cyc("R1 en",     1, 2'b01, 0, 0, 0, 0, 0, 0,  0, 0, 0, 2'b00);
        cyc("R1 fill",   0, 2'b00, 0, 0, 0, 1, A, 0,  0, 0, 0, 2'b01);
        cyc("R1 hit",    0, 2'b00, 1, A, 0, 0, 0, 0,  1, 0, 0, 2'b01);
        cfg_we = 0; fetch_valid = 0; fill_valid = 0; soft_rst = 0;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        cyc("R1 reg0",   0, 2'b00, 1, A, 0, 0, 0, 0,  0, 1, 0, 2'b00);
        cyc("R1 en2",    1, 2'b01, 0, 0, 0, 0, 0, 0,  0, 0, 0, 2'b00);
        cyc("R1 inval",  0, 2'b00, 1, A, 0, 0, 0, 0,  0, 1, 1, 2'b01);
        cyc("R2 idle",   0, 2'b00, 0, 0, 0, 0, 0, 0,  0, 0, 0, 2'b01);
        @(negedge clk);
        #3;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule